// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel

This block is one DMA channel that moves 32-bit words between system memory and a single peripheral data port. It takes its work from a chain of descriptors held in memory. Software starts the channel by writing one control word. That word holds the address of the first descriptor, a channel number and a go bit.

Once started, the channel runs without further help. It reads each seven-word descriptor, moves the words the descriptor asks for, and writes the descriptor's command word back with status bits set. It then follows the link to the next descriptor, and stops when the link is zero. At the end of the chain it can raise a one-cycle interrupt.

The direction of transfer is chosen per descriptor by a command bit, and so is the interrupt request. A halt bit in the same control word aborts the channel at any time.

Top module: `chain_dma_channel`

## Requirements
- R1: After reset the channel is idle. `irq` and `mem_req` are low, and `reg_rd_data` reads zero.
- R2: A control write with bit 3 set, issued while idle, starts the channel. The channel takes the descriptor address from bits 31:6 and the channel number from bits CH_W-1:0. Read-back gives the descriptor address in bits 31:6, busy in bit 3 and the channel number in bits CH_W-1:0.
- R3: A descriptor is fetched as seven reads at consecutive word addresses from its base, in this order: link, memory address, device address, length in words, stride, cycle count, command.
- R4: When command bit 12 is 1 (memory to device), the channel reads `length` words from ascending memory addresses, starting at the memory address and stepping by 4. It hands each word to the peripheral with `per_ack`, only while `per_req` is high. `per_addr` shows the fixed device address, and `per_ack` is never high together with `mem_req`.
- R5: When command bit 12 is 0 (device to memory), the channel takes each word from `per_rdata` in a cycle where `per_req` and `per_ack` are both high. It writes the words to ascending memory addresses.
- R6: After its data, each descriptor's command word is written back to base+24. Bit 2 is set in the written word. Bit 3 is also set when the link is zero.
- R7: A zero link ends the chain and the channel returns to idle. Any other link value is used as the next base, with its bits 5:0 dropped.
- R8: At the end of the chain, `irq` pulses for exactly one cycle if the last command has bit 1 set and bit 0 clear. Otherwise it stays low. The pulse occurs only while the channel is idle.
- R9: A descriptor with length zero moves no data and goes straight to its write-back.
- R10: A start write while busy is ignored. The descriptor address and channel number read back unchanged.
- R11: A control write with bit 4 set makes the channel idle on the next cycle, with no interrupt. The halt takes priority over a start bit in the same write.
- R12: A memory request keeps `mem_req` high and `mem_addr` unchanged until `mem_ready` is seen, unless a halt is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control word: descriptor address, halt, go, channel number |
| reg_rd_data | output | 32 | Descriptor address, busy flag and channel number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the access this cycle |
| per_req | input | 1 | Peripheral has a word ready or can accept one |
| per_ack | output | 1 | A word is exchanged with the peripheral this cycle |
| per_wr | output | 1 | Current descriptor moves memory to device |
| per_addr | output | 32 | Device address of the current descriptor |
| per_wdata | output | 32 | Word delivered to the peripheral |
| per_rdata | input | 32 | Word offered by the peripheral |
| irq | output | 1 | End-of-chain interrupt pulse |

## Verification
The assertions rely on the memory keeping `mem_rdata` valid in any cycle in which it raises `mem_ready`. They also rely on the peripheral holding `per_rdata` steady while `per_req` is high. A further assumption is that descriptors sit on 64-byte boundaries and buffers on 16-byte boundaries, within the modelled memory. The bench changes `mem_ready`, `per_req` and `per_rdata` only on the falling edge, and changes the offered word only after an acknowledge. It places every descriptor and buffer on the required boundaries.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    localparam int WORD_W       = 32;
    localparam int DESC_WORDS   = 7;
    localparam int IDX_W        = $clog2(DESC_WORDS);
    localparam int CTL_ADDR_LSB = 6;
    localparam int BASE_W       = WORD_W - CTL_ADDR_LSB;

    // descriptor field positions (fetch order)
    localparam int F_LINK   = 0;
    localparam int F_MEM    = 1;
    localparam int F_DEV    = 2;
    localparam int F_LEN    = 3;
    localparam int F_STRIDE = 4;
    localparam int F_CYC    = 5;
    localparam int F_CMD    = 6;

    // command word bits
    localparam int CB_MASK   = 0;
    localparam int CB_IRQ    = 1;
    localparam int CB_SEG    = 2;
    localparam int CB_ALL    = 3;
    localparam int CB_TO_DEV = 12;

    // control word bits
    localparam int CTL_GO   = 3;
    localparam int CTL_HALT = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_WAITDEV, S_MEM, S_PUT, S_WBACK
    } state_e;
endpackage

// File: rtl/cdma_desc_store.sv
module cdma_desc_store
    import cdma_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [DESC_WORDS-1:0][WORD_W-1:0]   words
);
    logic [DESC_WORDS-1:0][WORD_W-1:0] words_d, words_q;

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_comb begin
            words_d[g] = words_q[g];
            if (we && idx == IDX_W'(g))
                words_d[g] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) words_q <= '0;
        else        words_q <= words_d;
    end

    assign words = words_q;
endmodule

// File: rtl/cdma_sequencer.sv
module cdma_sequencer
    import cdma_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ctl_wr,
    input  logic [WORD_W-1:0]                   ctl_data,
    input  logic [DESC_WORDS-1:0][WORD_W-1:0]   desc,
    output logic                                store_we,
    output logic [IDX_W-1:0]                    store_idx,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [WORD_W-1:0]                   mem_addr,
    output logic [WORD_W-1:0]                   mem_wdata,
    input  logic [WORD_W-1:0]                   mem_rdata,
    input  logic                                mem_ready,
    input  logic                                per_req,
    output logic                                per_ack,
    output logic                                per_wr,
    output logic [WORD_W-1:0]                   per_addr,
    output logic [WORD_W-1:0]                   per_wdata,
    input  logic [WORD_W-1:0]                   per_rdata,
    output logic                                irq,
    output logic                                busy,
    output logic [BASE_W-1:0]                   desc_base,
    output logic [CH_W-1:0]                     chan_id
);
    localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W'(WORD_W / 8);
    localparam logic [WORD_W-1:0] CMD_OFFS   = WORD_W'(F_CMD) * WORD_BYTES;

    typedef struct packed {
        state_e             st;
        logic [IDX_W-1:0]   idx;
        logic [BASE_W-1:0]  base;
        logic [CH_W-1:0]    chan;
        logic [WORD_W-1:0]  ptr;
        logic [WORD_W-1:0]  cnt;
        logic [WORD_W-1:0]  data;
        logic               irq;
    } seq_t;

    seq_t q, d;

    logic [WORD_W-1:0] cmd, base_addr;
    logic to_dev, last, start, halt, step;

    assign cmd       = desc[F_CMD];
    assign to_dev    = cmd[CB_TO_DEV];
    assign last      = (desc[F_LINK] == '0);
    assign start     = ctl_wr && ctl_data[CTL_GO];
    assign halt      = ctl_wr && ctl_data[CTL_HALT];
    assign base_addr = {q.base, {CTL_ADDR_LSB{1'b0}}};

    logic unused_in;
    assign unused_in = ^{ctl_data[CTL_ADDR_LSB-1:0], desc[F_STRIDE], desc[F_CYC]};

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        step      = 1'b0;
        store_we  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        per_ack   = 1'b0;
        unique case (q.st)
            S_IDLE: if (start) begin
                d.base = ctl_data[WORD_W-1:CTL_ADDR_LSB];
                d.chan = ctl_data[CH_W-1:0];
                d.idx  = '0;
                d.st   = S_FETCH;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = base_addr + WORD_W'(q.idx) * WORD_BYTES;
                if (mem_ready) begin
                    store_we = 1'b1;
                    d.idx    = q.idx + 1'b1;
                    if (q.idx == IDX_W'(DESC_WORDS - 1)) d.st = S_DECODE;
                end
            end
            S_DECODE: begin
                d.ptr = desc[F_MEM];
                d.cnt = desc[F_LEN];
                if (desc[F_LEN] == '0) d.st = S_WBACK;
                else if (to_dev)       d.st = S_MEM;
                else                   d.st = S_WAITDEV;
            end
            S_WAITDEV: begin
                per_ack = per_req;
                if (per_req) begin
                    d.data = per_rdata;
                    d.st   = S_MEM;
                end
            end
            S_MEM: begin
                mem_req   = 1'b1;
                mem_we    = !to_dev;
                mem_addr  = q.ptr;
                mem_wdata = q.data;
                if (mem_ready) begin
                    if (to_dev) begin
                        d.data = mem_rdata;
                        d.st   = S_PUT;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            S_PUT: begin
                per_ack = per_req;
                step    = per_req;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_addr + CMD_OFFS;
                mem_wdata = cmd | (WORD_W'(1) << CB_SEG) | (WORD_W'(last) << CB_ALL);
                if (mem_ready) begin
                    if (last) begin
                        d.st  = S_IDLE;
                        d.irq = cmd[CB_IRQ] && !cmd[CB_MASK];
                    end else begin
                        d.base = desc[F_LINK][WORD_W-1:CTL_ADDR_LSB];
                        d.idx  = '0;
                        d.st   = S_FETCH;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (step) begin
            d.ptr = q.ptr + WORD_BYTES;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == WORD_W'(1)) d.st = S_WBACK;
            else if (to_dev)         d.st = S_MEM;
            else                     d.st = S_WAITDEV;
        end
        if (halt) begin
            d.st  = S_IDLE;
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign store_idx = q.idx;
    assign per_wr    = to_dev;
    assign per_addr  = desc[F_DEV];
    assign per_wdata = q.data;
    assign irq       = q.irq;
    assign busy      = (q.st != S_IDLE);
    assign desc_base = q.base;
    assign chan_id   = q.chan;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready && !halt |=> mem_req && $stable(mem_addr));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);
    // R11
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !busy && !irq);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !halt && q.st != S_WBACK |=> $stable(desc_base) && $stable(chan_id));
    // R4
    ack_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> !mem_req);
    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == S_DECODE && desc[F_LEN] == '0 && !halt |=> q.st == S_WBACK && !per_ack);
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel #(
    parameter int CH_W = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    input  logic        per_req,
    output logic        per_ack,
    output logic        per_wr,
    output logic [31:0] per_addr,
    output logic [31:0] per_wdata,
    input  logic [31:0] per_rdata,
    output logic        irq
);
    import cdma_pkg::*;

    logic [DESC_WORDS-1:0][WORD_W-1:0] desc_words;
    logic                              store_we, busy;
    logic [IDX_W-1:0]                  store_idx;
    logic [BASE_W-1:0]                 desc_base;
    logic [CH_W-1:0]                   chan_id;

    cdma_desc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .idx   (store_idx),
        .wdata (mem_rdata),
        .words (desc_words)
    );

    cdma_sequencer #(.CH_W(CH_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (reg_wr_en),
        .ctl_data  (reg_wr_data),
        .desc      (desc_words),
        .store_we  (store_we),
        .store_idx (store_idx),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .per_req   (per_req),
        .per_ack   (per_ack),
        .per_wr    (per_wr),
        .per_addr  (per_addr),
        .per_wdata (per_wdata),
        .per_rdata (per_rdata),
        .irq       (irq),
        .busy      (busy),
        .desc_base (desc_base),
        .chan_id   (chan_id)
    );

    always_comb begin
        reg_rd_data                            = '0;
        reg_rd_data[WORD_W-1:CTL_ADDR_LSB]     = desc_base;
        reg_rd_data[CTL_GO]                    = busy;
        reg_rd_data[CH_W-1:0]                  = chan_id;
    end
endmodule

// File: tb/tb_chain_dma_channel.sv
`timescale 1ns/1ps
module tb_chain_dma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        per_req = 1'b0, per_ack, per_wr;
    logic [31:0] per_addr, per_wdata, per_rdata;
    logic        irq;

    always #10 clk = ~clk;

    chain_dma_channel dut (.*);

    int tests = 0, fails = 0, cycles = 0, irq_cnt = 0;
    logic [31:0] mem [0:255];
    logic [63:0] exp_wr[$];
    logic [31:0] exp_per[$], src_q[$], rd_log[$];
    logic [31:0] exp_dev = '0;
    logic [7:0]  lfsr = 8'hA5;
    logic stall = 1'b0, src_adv = 1'b0, prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;

    assign mem_rdata = mem[mem_addr[9:2]];
    assign per_rdata = (src_q.size() > 0) ? src_q[0] : 32'h0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus and peripheral model, checked every clock
    always @(negedge clk) begin
        cycles++;
        if (src_adv) void'(src_q.pop_front());
        src_adv = 1'b0;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = lfsr[0] | lfsr[2];
        per_req = !stall && (lfsr[1] | lfsr[4]);
        #1;
        if (rst_n) begin
            if (prev_pend) // R12
                chk(mem_req && mem_addr == prev_addr, "R12 request held", {31'b0, mem_req, mem_addr}, {32'h1, prev_addr});
            prev_pend = mem_req && !mem_ready && !(reg_wr_en && reg_wr_data[4]);
            prev_addr = mem_addr;
            if (irq) irq_cnt++;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    if (exp_wr.size() == 0)
                        chk(1'b0, "R5/R6 unexpected write", {mem_addr, mem_wdata}, 64'h0);
                    else begin
                        logic [63:0] e;
                        e = exp_wr.pop_front();
                        chk({mem_addr, mem_wdata} == e, "R5/R6 write", {mem_addr, mem_wdata}, e);
                    end
                    mem[mem_addr[9:2]] = mem_wdata;
                end else rd_log.push_back(mem_addr);
            end
            if (per_ack) begin
                chk(per_req, "R4 ack without request", 64'(per_req), 64'h1);
                if (per_wr) begin
                    if (exp_per.size() == 0)
                        chk(1'b0, "R4 unexpected word", 64'(per_wdata), 64'h0);
                    else begin
                        logic [31:0] e;
                        e = exp_per.pop_front();
                        chk(per_wdata == e && per_addr == exp_dev, "R4 peripheral word",
                            {per_addr, per_wdata}, {exp_dev, e});
                    end
                end else begin
                    chk(src_q.size() > 0, "R5 unexpected fetch from device", 64'(src_q.size()), 64'h1);
                    src_adv = 1'b1;
                end
            end
        end
        if (cycles > 100000) begin
            chk(1'b0, "watchdog", 64'(cycles), 64'd100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic ctl(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic put_desc(input int base, input int link, input int maddr, input int daddr,
                            input int len, input int cmd);
        mem[base/4+0] = link;  mem[base/4+1] = maddr; mem[base/4+2] = daddr;
        mem[base/4+3] = len;   mem[base/4+4] = 0;     mem[base/4+5] = 1;
        mem[base/4+6] = cmd;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        do begin @(negedge clk); #2; n++; end while (reg_rd_data[3] && n < 3000);
        chk(!reg_rd_data[3], tag, 64'(reg_rd_data), 64'h0);
    endtask

    task automatic end_checks(input string tag, input int irq_exp);
        repeat (3) @(negedge clk);
        #2;
        chk(exp_wr.size() == 0 && exp_per.size() == 0 && src_q.size() == 0,
            {tag, " all transfers done"}, 64'(exp_wr.size() + exp_per.size() + src_q.size()), 64'h0);
        chk(irq_cnt == irq_exp, {tag, " irq pulses"}, 64'(irq_cnt), 64'(irq_exp));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        #2;
        // R1
        chk(reg_rd_data == 0 && !irq && !mem_req, "R1 reset state", {reg_rd_data, 30'b0, irq, mem_req}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Test A: single memory-to-device descriptor, interrupt requested (R2 R3 R4 R6 R7 R8)
        put_desc(32'h100, 0, 32'h200, 32'hA000_0010, 3, 32'h1002);
        for (int i = 0; i < 3; i++) begin
            mem[32'h200/4 + i] = 32'h1111_0000 + i;
            exp_per.push_back(32'h1111_0000 + i);
        end
        exp_dev = 32'hA000_0010;
        exp_wr.push_back({32'h118, 32'h100E});
        rd_log.delete(); irq_cnt = 0;
        ctl(32'h100 | 32'h8 | 32'h1);
        #2;
        chk(reg_rd_data == 32'h109, "R2 readback after start", 64'(reg_rd_data), 64'h109);
        wait_idle("R7 chain ends on null link");
        end_checks("R8 enabled", 1);
        chk(rd_log.size() == 10, "R3 read count", 64'(rd_log.size()), 64'd10);
        for (int i = 0; i < 10 && i < rd_log.size(); i++) begin
            logic [31:0] e;
            e = (i < 7) ? 32'h100 + 4*i : 32'h200 + 4*(i-7);
            chk(rd_log[i] == e, "R3/R4 read address order", 64'(rd_log[i]), 64'(e));
        end
        chk(mem[32'h118/4] == 32'h100E, "R6 last status bits", 64'(mem[32'h118/4]), 64'h100E);

        // Test B: device-to-memory chain with a zero-length middle, irq masked (R5 R6 R7 R8 R9)
        put_desc(32'h140, 32'h180, 32'h300, 32'hB000_0020, 2, 32'h2);
        put_desc(32'h180, 32'h1C0, 32'h320, 32'hB000_0020, 0, 32'h2);
        put_desc(32'h1C0, 0,       32'h340, 32'hB000_0020, 3, 32'h3);
        for (int k = 0; k < 5; k++) src_q.push_back(32'hC0DE_0000 + k);
        exp_wr.push_back({32'h300, 32'hC0DE_0000});
        exp_wr.push_back({32'h304, 32'hC0DE_0001});
        exp_wr.push_back({32'h158, 32'h6});
        exp_wr.push_back({32'h198, 32'h6}); // R9: no data between these write-backs
        exp_wr.push_back({32'h340, 32'hC0DE_0002});
        exp_wr.push_back({32'h344, 32'hC0DE_0003});
        exp_wr.push_back({32'h348, 32'hC0DE_0004});
        exp_wr.push_back({32'h1D8, 32'hF});
        irq_cnt = 0;
        ctl(32'h140 | 32'h8 | 32'h3);
        wait_idle("R7 chain of three");
        end_checks("R8 masked", 0);
        chk(mem[32'h320/4] == 0, "R9 zero length left buffer alone", 64'(mem[32'h320/4]), 64'h0);
        chk(mem[32'h348/4] == 32'hC0DE_0004, "R5 last word stored", 64'(mem[32'h348/4]), 64'hC0DE_0004);

        // Test C: start while busy ignored, then halt (R10 R11)
        put_desc(32'h100, 0, 32'h200, 32'hA000_0010, 4, 32'h1002);
        stall = 1'b1; irq_cnt = 0;
        ctl(32'h100 | 32'h8 | 32'h2);
        repeat (40) @(negedge clk);
        #2;
        chk(reg_rd_data == 32'h10A, "R2 busy readback", 64'(reg_rd_data), 64'h10A);
        ctl(32'h140 | 32'h8 | 32'h1);
        #2;
        chk(reg_rd_data == 32'h10A, "R10 start while busy ignored", 64'(reg_rd_data), 64'h10A);
        ctl(32'h10);
        #2;
        chk(!reg_rd_data[3] && !mem_req, "R11 halt idles at once", {reg_rd_data, 31'b0, mem_req}, 64'h0);
        stall = 1'b0;
        repeat (30) @(negedge clk);
        #2;
        chk(irq_cnt == 0 && !reg_rd_data[3], "R11 no irq or restart after halt", 64'(irq_cnt), 64'h0);

        // Test D: halt wins over start in the same write (R11)
        ctl(32'h140 | 32'h18);
        #2;
        chk(!reg_rd_data[3] && !mem_req, "R11 halt priority over start", 64'(reg_rd_data), 64'h0);
        repeat (5) @(negedge clk);

        // Test E: memory-to-device, interrupt bit clear (R8)
        put_desc(32'h100, 0, 32'h210, 32'hA000_0030, 2, 32'h1000);
        mem[32'h210/4] = 32'h5A5A_0001; mem[32'h214/4] = 32'h5A5A_0002;
        exp_per.push_back(32'h5A5A_0001); exp_per.push_back(32'h5A5A_0002);
        exp_dev = 32'hA000_0030;
        exp_wr.push_back({32'h118, 32'h100C});
        irq_cnt = 0;
        ctl(32'h100 | 32'h8);
        wait_idle("R7 single descriptor");
        end_checks("R8 not requested", 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule